// File: doc/BRIEF.md
# Lockable Fan-Monitor Control Register

This block is the central control and status register of a hardware-monitor fan controller. It sits behind a plain register bus that carries an address, a write strobe, write data and read data. It holds four live bits. The start bit chooses between programmed and built-in fan parameters. The lock bit write-protects the parameter bank. The ready flag reports that power-up and the converters are good. The override bit forces every PWM output to full duty.

The block also decodes writes aimed at the fan limit and parameter bank, which sits at addresses 5Ch to 6Eh. It emits a per-write enable for that bank, and the enable is withheld while the lock is set. Once software sets the lock, the lock stays set until the next power-on reset. Start and override stay writable under the lock.

For every PWM channel the block combines the channel's disable request with the override. This gives a per-channel run signal in which the override always wins.

Top module: `monctl_lockreg`

## Requirements
- R1: After reset (rst_n low at a rising edge) the register reads 00h, use_prog_params, bank_wr_protect and force_full_duty are 0, and bank_wr_en is 0.
- R2: Register bits 7..4 are reserved: they always read 0 and a write to them changes nothing observable.
- R3: A write to address 40h loads bit 0 (start) from write data bit 0, at the next edge, whether or not the lock is set. use_prog_params equals the start bit, and 1 selects programmed parameters.
- R4: Writing 1 to bit 1 (lock) sets it at the next edge. Writing 0 never clears it; only reset does. bank_wr_protect equals the lock bit.
- R5: bank_wr_en is 1 in the same cycle exactly when bus_wr is 1, bus_addr lies in 5Ch..6Eh inclusive, and lock is 0. Addresses 5Bh and 6Fh never enable it.
- R6: Bit 2 (ready) is read-only. It becomes 1 on the third rising edge after hw_ready_in is first sampled high, which is two synchroniser stages and a capture. It stays 1 until reset even if hw_ready_in falls. Writes to bit 2 are ignored.
- R7: A write to address 40h loads bit 3 (override) from write data bit 3 at the next edge, even under lock. force_full_duty equals the override bit.
- R8: For each channel i, pwm_ch_run[i] is 1 when pwm_ch_disable[i] is 0 or when override is 1. Override beats the disabled mode.
- R9: bus_rdata shows {0000, override, ready, lock, start} combinationally while bus_addr is 40h, and reads 00h at any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| bus_addr | input | 8 | Register bus address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the control register |
| hw_ready_in | input | 1 | Asynchronous power-up and converter-good indication |
| pwm_ch_disable | input | NCH (4) | Per-channel disabled-mode request |
| use_prog_params | output | 1 | 1: use programmed fan parameters, 0: built-in defaults |
| bank_wr_protect | output | 1 | Parameter bank is write-protected |
| bank_wr_en | output | 1 | Qualified write enable for the parameter bank |
| force_full_duty | output | 1 | Drive every PWM output at 100% duty |
| pwm_ch_run | output | NCH (4) | Per-channel run permission after override |

## Verification
The bench aims first at the lock. It writes 0 to the lock after setting it, and it writes 5Ch, 6Eh and the neighbours 5Bh and 6Fh both before and after locking. A design that let a zero clear the lock, or that had an off-by-one bank edge, would show a wrong read value or a stray bank enable. The bench then changes start and override under the lock, because a design that gated the whole register would freeze them. The bench pulses hw_ready_in high and then low. A design with the wrong synchroniser depth would set ready one cycle early or late, and a design with a non-sticky flag would lose ready. Disable patterns are combined with override to catch a design that lets the disabled mode beat the forced full duty.

// File: rtl/monctl_pkg.sv
// Package: shared address map, bit positions and the control field type.
// Assumes an 8-bit register address space.
package monctl_pkg;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 8;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h40;
    localparam logic [ADDR_W-1:0] BANK_LO   = 8'h5C;
    localparam logic [ADDR_W-1:0] BANK_HI   = 8'h6E;

    localparam int unsigned BIT_START = 0;
    localparam int unsigned BIT_LOCK  = 1;
    localparam int unsigned BIT_READY = 2;
    localparam int unsigned BIT_OVR   = 3;

    // Live control state held by the register.
    typedef struct packed {
        logic ovr;
        logic ready;
        logic lock;
        logic start;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{ovr: 1'b0, ready: 1'b0, lock: 1'b0, start: 1'b0};

endpackage

// File: rtl/monctl_addr_decode.sv
// Module: address decoder. Flags a hit on the control register and a hit
// anywhere in the inclusive parameter-bank window. Purely combinational;
// assumes LO <= HI.
module monctl_addr_decode #(
    parameter int unsigned             AW      = 8,
    parameter logic [AW-1:0]           CTRL_AT = 8'h40,
    parameter logic [AW-1:0]           LO      = 8'h5C,
    parameter logic [AW-1:0]           HI      = 8'h6E
) (
    input  logic [AW-1:0] addr,
    output logic          hit_ctrl,
    output logic          hit_bank
);

    // Compare the address against the register and the window bounds.
    always_comb begin
        hit_ctrl = (addr == CTRL_AT);
        hit_bank = (addr >= LO) && (addr <= HI);
    end

endmodule

// File: rtl/monctl_ready_sync.sv
// Module: ready flag. Brings an asynchronous converter-good level through
// SYNC_STAGES flops, then captures it into a sticky flag that only reset
// clears. Assumes the input stays high long enough to pass the flops.
module monctl_ready_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic ready_o
);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   ready_q;

    // Shift the raw level through the synchroniser chain.
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[SYNC_STAGES-2:0], async_in};
            end
        end
    endgenerate

    // Latch the synchronised level; never falls until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                    ready_q <= 1'b0;
        else if (chain_q[SYNC_STAGES-1]) ready_q <= 1'b1;
    end

    assign ready_o = ready_q;

endmodule

// File: rtl/monctl_ctrl_reg.sv
// Module: control bits. Start and override load on every control write;
// the lock only ever sets from a control write and clears on reset alone.
// Assumes wr_hit is already qualified by the write strobe.
module monctl_ctrl_reg #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [DW-1:0] wdata,
    output logic          start_o,
    output logic          lock_o,
    output logic          ovr_o
);
    import monctl_pkg::*;

    logic start_q, lock_q, ovr_q;
    logic unused_wbits;

    // Start and override: freely writable, lock has no say.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else if (wr_hit) begin
            start_q <= wdata[BIT_START];
            ovr_q   <= wdata[BIT_OVR];
        end
    end

    // Lock: set-only, so a written zero is simply not acted on.
    always_ff @(posedge clk) begin
        if (!rst_n)                         lock_q <= 1'b0;
        else if (wr_hit && wdata[BIT_LOCK]) lock_q <= 1'b1;
    end

    assign unused_wbits = ^{wdata[DW-1:BIT_OVR+1], wdata[BIT_READY]};
    assign start_o = start_q;
    assign lock_o  = lock_q;
    assign ovr_o   = ovr_q;

endmodule

// File: rtl/monctl_lockreg.sv
// Module: top of the lockable fan-monitor control register. Decodes the
// bus, holds the control bits, gates bank writes with the lock and folds
// the override into per-channel run permissions. Single clock; reset is
// the power-on reset and is synchronous, active low.
module monctl_lockreg #(
    parameter int unsigned NCH         = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [monctl_pkg::ADDR_W-1:0] bus_addr,
    input  logic                          bus_wr,
    input  logic [monctl_pkg::DATA_W-1:0] bus_wdata,
    output logic [monctl_pkg::DATA_W-1:0] bus_rdata,
    input  logic                          hw_ready_in,
    input  logic [NCH-1:0]                pwm_ch_disable,
    output logic                          use_prog_params,
    output logic                          bank_wr_protect,
    output logic                          bank_wr_en,
    output logic                          force_full_duty,
    output logic [NCH-1:0]                pwm_ch_run
);
    import monctl_pkg::*;

    localparam int unsigned RSV_W = DATA_W - 4;

    logic  hit_ctrl, hit_bank;
    logic  start_b, lock_b, ovr_b, ready_flag;
    ctrl_t ctrl;

    monctl_addr_decode #(
        .AW(ADDR_W), .CTRL_AT(CTRL_ADDR), .LO(BANK_LO), .HI(BANK_HI)
    ) u_dec (
        .addr(bus_addr), .hit_ctrl(hit_ctrl), .hit_bank(hit_bank)
    );

    monctl_ctrl_reg #(.DW(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_hit(bus_wr && hit_ctrl),
        .wdata(bus_wdata), .start_o(start_b), .lock_o(lock_b), .ovr_o(ovr_b)
    );

    monctl_ready_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rdy (
        .clk(clk), .rst_n(rst_n), .async_in(hw_ready_in), .ready_o(ready_flag)
    );

    // Gather the live bits into the register view.
    always_comb begin
        ctrl       = CTRL_RESET;
        ctrl.start = start_b;
        ctrl.lock  = lock_b;
        ctrl.ready = ready_flag;
        ctrl.ovr   = ovr_b;
    end

    // Read mux: the control register at its address, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl) bus_rdata = {{RSV_W{1'b0}}, ctrl};
    end

    // Side-band controls and the lock-gated bank write enable.
    always_comb begin
        use_prog_params = ctrl.start;
        bank_wr_protect = ctrl.lock;
        force_full_duty = ctrl.ovr;
        bank_wr_en      = bus_wr && hit_bank && !ctrl.lock;
    end

    // Per-channel run permission: override wins over the disabled mode.
    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            assign pwm_ch_run[c] = ctrl.ovr || !pwm_ch_disable[c];
        end
    endgenerate

endmodule

// File: rtl/monctl_lockreg_chk.sv
// Module: assertion checker for monctl_lockreg, attached by bind below.
module monctl_lockreg_chk #(
    parameter int unsigned NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [7:0]     bus_addr,
    input logic           bus_wr,
    input logic [7:0]     bus_wdata,
    input logic [7:0]     bus_rdata,
    input logic           ready_flag,
    input logic           use_prog_params,
    input logic           bank_wr_protect,
    input logic           bank_wr_en,
    input logic           force_full_duty,
    input logic [NCH-1:0] pwm_ch_run
);

    assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[7:4] == 4'h0);

    assert_start_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h40) |=> (use_prog_params == $past(bus_wdata[0])));

    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr_protect |=> bank_wr_protect);

    assert_bank_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr_protect |-> !bank_wr_en);

    assert_ready_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ready_flag |=> ready_flag);

    assert_ovr_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h40) |=> (force_full_duty == $past(bus_wdata[3])));

    assert_ovr_beats_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        force_full_duty |-> ($countones(pwm_ch_run) == NCH));

endmodule

bind monctl_lockreg monctl_lockreg_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ready_flag(ready_flag),
    .use_prog_params(use_prog_params), .bank_wr_protect(bank_wr_protect),
    .bank_wr_en(bank_wr_en), .force_full_duty(force_full_duty),
    .pwm_ch_run(pwm_ch_run)
);

// File: tb/sim_monctl_lockreg.sv
// Bench: behavioural reference model updated on each rising edge and
// compared against every output on each falling edge.
module sim_monctl_lockreg;

    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [7:0]     bus_addr = 8'h00;
    logic           bus_wr = 1'b0;
    logic [7:0]     bus_wdata = 8'h00;
    logic [7:0]     bus_rdata;
    logic           hw_ready_in = 1'b0;
    logic [NCH-1:0] pwm_ch_disable = '0;
    logic           use_prog_params, bank_wr_protect, bank_wr_en, force_full_duty;
    logic [NCH-1:0] pwm_ch_run;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // reference state
    int m_start = 0, m_lock = 0, m_ovr = 0, m_ready = 0, s1 = 0, s2 = 0;

    always #4 clk = ~clk;

    monctl_lockreg #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_ready_in(hw_ready_in),
        .pwm_ch_disable(pwm_ch_disable), .use_prog_params(use_prog_params),
        .bank_wr_protect(bank_wr_protect), .bank_wr_en(bank_wr_en),
        .force_full_duty(force_full_duty), .pwm_ch_run(pwm_ch_run)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: register behaviour as stated in the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_start = 0; m_lock = 0; m_ovr = 0; m_ready = 0; s1 = 0; s2 = 0;
        end else begin
            if (bus_wr && bus_addr == 8'h40) begin
                m_start = bus_wdata[0];
                m_ovr   = bus_wdata[3];
                if (bus_wdata[1]) m_lock = 1;
            end
            if (s2 != 0) m_ready = 1;
            s2 = s1;
            s1 = hw_ready_in;
        end
    end

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int exp_rd;
            int in_bank;
            exp_rd  = (bus_addr == 8'h40) ? (m_ovr * 8 + m_ready * 4 + m_lock * 2 + m_start) : 0;
            in_bank = (bus_addr >= 8'h5C && bus_addr <= 8'h6E) ? 1 : 0;
            chk("R9 rdata", bus_rdata, exp_rd);
            chk("R3 use_prog_params", use_prog_params, m_start);
            chk("R4 bank_wr_protect", bank_wr_protect, m_lock);
            chk("R5 bank_wr_en", bank_wr_en, (bus_wr && in_bank && !m_lock) ? 1 : 0);
            chk("R7 force_full_duty", force_full_duty, m_ovr);
            for (int i = 0; i < NCH; i++)
                chk("R8 pwm_ch_run", pwm_ch_run[i], (m_ovr != 0 || !pwm_ch_disable[i]) ? 1 : 0);
        end
    end

    task automatic step(input logic [7:0] a, input logic w, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wr = w; bus_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(8'h40, 1'b0, 8'h00);
    endtask

    task automatic do_reset();
        @(posedge clk); #1; rst_n = 0;
        idle(3);
        @(posedge clk); #1; rst_n = 1;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_checks++; n_fail++;
        done = 1;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        do_reset();
        // R1: reset state at the ports
        #2;
        chk("R1 rdata after reset", bus_rdata, 0);
        chk("R1 outputs after reset", {use_prog_params, bank_wr_protect, bank_wr_en, force_full_duty}, 0);

        // R5: bank window edges while unlocked
        step(8'h5B, 1, 8'h11); #2; chk("R5 5Bh below window", bank_wr_en, 0);
        step(8'h5C, 1, 8'h11); #2; chk("R5 5Ch low edge", bank_wr_en, 1);
        step(8'h6E, 1, 8'h11); #2; chk("R5 6Eh high edge", bank_wr_en, 1);
        step(8'h6F, 1, 8'h11); #2; chk("R5 6Fh above window", bank_wr_en, 0);
        step(8'h60, 0, 8'h11); #2; chk("R5 no strobe", bank_wr_en, 0);

        // R2/R6: reserved and ready bits written, must read back 0
        step(8'h40, 1, 8'hF4);
        step(8'h40, 0, 8'h00); #2;
        chk("R2 reserved ignored", bus_rdata[7:4], 0);
        chk("R6 ready not writable", bus_rdata[2], 0);

        // R3, R7, R8: start and override with disable patterns
        pwm_ch_disable = 4'b1010;
        step(8'h40, 1, 8'h01);
        step(8'h40, 0, 8'h00); #2;
        chk("R3 start set", use_prog_params, 1);
        chk("R8 disable respected", pwm_ch_run, 4'b0101);
        step(8'h40, 1, 8'h08);
        step(8'h40, 0, 8'h00); #2;
        chk("R7 override set", force_full_duty, 1);
        chk("R8 override beats disable", pwm_ch_run, 4'b1111);
        chk("R3 start cleared", use_prog_params, 0);

        // R6: ready rises on the third edge, stays after input drops
        step(8'h40, 0, 8'h00);
        hw_ready_in = 1;
        idle(2); #2; chk("R6 ready not yet", bus_rdata[2], 0);
        idle(1); #2; chk("R6 ready set", bus_rdata[2], 1);
        hw_ready_in = 0;
        idle(5); #2; chk("R6 ready sticky", bus_rdata[2], 1);

        // R4: set lock, try to clear it
        step(8'h40, 1, 8'h02);
        step(8'h40, 1, 8'h00);
        step(8'h40, 0, 8'h00); #2;
        chk("R4 lock survives zero write", bus_rdata[1], 1);
        step(8'h5C, 1, 8'hAA); #2; chk("R5 bank blocked under lock", bank_wr_en, 0);
        step(8'h6E, 1, 8'hAA); #2; chk("R5 bank blocked high edge", bank_wr_en, 0);

        // R3/R7 writable under lock
        step(8'h40, 1, 8'h09);
        step(8'h40, 0, 8'h00); #2;
        chk("R3 start under lock", use_prog_params, 1);
        chk("R7 override under lock", force_full_duty, 1);
        step(8'h40, 1, 8'h00);
        step(8'h40, 0, 8'h00); #2;
        chk("R7 override cleared under lock", force_full_duty, 0);
        chk("R4 lock still set", bank_wr_protect, 1);
        pwm_ch_disable = 4'b0110;
        #1; chk("R8 disable without override", pwm_ch_run, 4'b1001);

        // R9: other addresses read zero
        step(8'h41, 0, 8'h00); #2; chk("R9 other address", bus_rdata, 0);

        // R1/R4: only reset clears lock and ready
        do_reset();
        #2;
        chk("R1 lock cleared by reset", bank_wr_protect, 0);
        chk("R1 rdata after second reset", bus_rdata, 0);
        step(8'h60, 1, 8'h00); #2; chk("R5 bank open after reset", bank_wr_en, 1);

        idle(2);
        done = 1;
        summary();
    end

endmodule